// File: doc/BRIEF.md
# Hardware Stack Engine

This block owns a downward-growing stack pointer and turns stack commands into byte accesses on a simple synchronous SRAM. A command is a push of one data byte, a pop of one data byte, a call that saves a 22-bit return address as three bytes, or a return that reads those three bytes back and rebuilds the address. One SRAM access is made per clock. Single-byte pushes finish in the cycle they are accepted. Pops and the three-byte sequences keep the engine busy for a few cycles.

Commands use a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a multi-cycle sequence runs and in any cycle in which the register port writes. A source that sees `cmd_ready` low must hold or retry its command. Results are a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take them in that cycle.

Software reads and writes the pointer as two byte registers through a small register port. A parameter can remove the high byte when the data space fits in 8 bits. A sticky fault flag reports any push that writes into the reserved region at or below address 0x0100.

Top module: `stack_engine`

## Requirements
- R1: After reset the pointer equals parameter SRAM_LAST (default 0x04FF), `fault` is 0, `busy` is 0 and `cmd_ready` is 1.
- R2: An accepted push (`cmd_op` = 0) writes `cmd_data` at the current pointer in the same cycle, and the pointer drops by one on that edge.
- R3: An accepted pop (`cmd_op` = 1) raises the pointer by one and reads the byte at the new address. `rsp_valid` goes high in the cycle after acceptance, with that byte on `rsp_data`.
- R4: An accepted call (`cmd_op` = 2) writes return-address bits [7:0] at the pointer, then bits [15:8] at pointer-1, then bits [21:16] (zero-extended) at pointer-2, one write per clock. The pointer drops by three in total.
- R5: An accepted return (`cmd_op` = 3) reads the high, middle and low bytes from pointer+1, +2 and +3, in that order. The pointer rises by three. `rsp_valid` pulses three cycles after acceptance, with the rebuilt address on `rsp_ra`.
- R6: While `busy` is high, `cmd_ready` is low and any command offered is ignored.
- R7: A register write (`reg_sel` 0 = low byte, 1 = high byte) changes the pointer on the next clock edge. `reg_rdata` shows the byte chosen by `reg_sel`.
- R8: A register write in the same cycle as an offered command wins. The command is not accepted and no SRAM access is made for it.
- R9: A push write (data or return-address byte) to an address at or below 0x0100 sets `fault`. The flag stays set until reset.
- R10: With HAS_HIGH = 0 the pointer is 8 bits wide. The high register reads 0 and ignores writes, and fault detection is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| cmd_data | input | 8 | Byte to push |
| cmd_ra | input | RA_W | Return address to save on a call |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | 8 | Popped byte |
| rsp_ra | output | RA_W | Rebuilt return address |
| busy | output | 1 | Multi-cycle sequence running |
| fault | output | 1 | Sticky reserved-region write flag |
| mem_addr | output | 16 | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable; data returns next cycle |
| mem_rdata | input | 8 | SRAM read data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 low byte, 1 high byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register byte |

## Verification
The bound checker checks on every cycle the rules that a property can express. These are the push address and the one-step pointer moves, the three-step moves around calls and returns, and when the result pulse appears. They also include the blocking of `cmd_ready` while busy or while a register write is made, and the stickiness and trigger of the fault flag. The scenarios show what only data values can show. These are the byte order in SRAM after a call, the address rebuilt by nested returns, LIFO order of data bytes, a command dropped while busy, register write timing, and the reduced variant with no high byte.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP_RD,
    ST_CALL_MID,
    ST_CALL_HI,
    ST_RET_MID,
    ST_RET_LO,
    ST_RET_DONE
  } stk_st_e;

  localparam int ADDR_W = 16;
endpackage

// File: rtl/stack_ptr.sv
module stack_ptr
  import stack_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_VAL = 16'h04FF,
  parameter bit                HAS_HIGH  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_dn,
  input  logic              step_up,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [ADDR_W-1:0] sp,
  output logic [7:0]        reg_rdata
);
  generate
    if (HAS_HIGH) begin : g_wide
      logic [15:0] sp_q;
      always_ff @(posedge clk) begin
        if (!rst_n)         sp_q <= RESET_VAL;
        else if (reg_we) begin
          if (reg_sel)      sp_q[15:8] <= reg_wdata;
          else              sp_q[7:0]  <= reg_wdata;
        end
        else if (step_dn)   sp_q <= sp_q - 16'd1;
        else if (step_up)   sp_q <= sp_q + 16'd1;
      end
      assign sp        = sp_q;
      assign reg_rdata = reg_sel ? sp_q[15:8] : sp_q[7:0];
    end else begin : g_narrow
      logic [7:0] sp_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                sp_q <= RESET_VAL[7:0];
        else if (reg_we) begin
          if (!reg_sel)            sp_q <= reg_wdata;
        end
        else if (step_dn)          sp_q <= sp_q - 8'd1;
        else if (step_up)          sp_q <= sp_q + 8'd1;
      end
      assign sp        = {8'h00, sp_q};
      assign reg_rdata = reg_sel ? 8'h00 : sp_q;
    end
  endgenerate
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_pkg::*;
#(
  parameter int RA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic [RA_W-1:0]   cmd_ra,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] sp,
  input  logic [7:0]        mem_rdata,
  output logic              cmd_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              step_dn,
  output logic              step_up,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [RA_W-1:0]   rsp_ra
);
  localparam int HI_W = RA_W - 16;
  localparam int UP_W = RA_W - 8;

  stk_st_e          state_q, state_d;
  logic [UP_W-1:0]  up_q;
  logic [ADDR_W-1:0] sp_next_up;
  logic [7:0]       hi_byte;
  logic             take;
  stk_op_e          op;

  assign op         = stk_op_e'(cmd_op);
  assign busy       = (state_q != ST_IDLE);
  assign cmd_ready  = !busy && !reg_we;
  assign take       = cmd_valid && cmd_ready;
  assign sp_next_up = sp + 16'd1;

  always_comb begin
    hi_byte = '0;
    hi_byte[HI_W-1:0] = up_q[UP_W-1:8];
  end

  always_comb begin
    state_d   = state_q;
    mem_addr  = sp;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    step_dn   = 1'b0;
    step_up   = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = '0;
    rsp_ra    = '0;
    unique case (state_q)
      ST_IDLE: if (take) begin
        unique case (op)
          OP_PUSH: begin
            mem_we = 1'b1; mem_wdata = cmd_data; step_dn = 1'b1;
          end
          OP_POP: begin
            mem_re = 1'b1; mem_addr = sp_next_up; step_up = 1'b1;
            state_d = ST_POP_RD;
          end
          OP_CALL: begin
            mem_we = 1'b1; mem_wdata = cmd_ra[7:0]; step_dn = 1'b1;
            state_d = ST_CALL_MID;
          end
          OP_RET: begin
            mem_re = 1'b1; mem_addr = sp_next_up; step_up = 1'b1;
            state_d = ST_RET_MID;
          end
        endcase
      end
      ST_POP_RD: begin
        rsp_valid = 1'b1; rsp_data = mem_rdata; state_d = ST_IDLE;
      end
      ST_CALL_MID: begin
        mem_we = 1'b1; mem_wdata = up_q[7:0]; step_dn = 1'b1;
        state_d = ST_CALL_HI;
      end
      ST_CALL_HI: begin
        mem_we = 1'b1; mem_wdata = hi_byte; step_dn = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RET_MID: begin
        mem_re = 1'b1; mem_addr = sp_next_up; step_up = 1'b1;
        state_d = ST_RET_LO;
      end
      ST_RET_LO: begin
        mem_re = 1'b1; mem_addr = sp_next_up; step_up = 1'b1;
        state_d = ST_RET_DONE;
      end
      ST_RET_DONE: begin
        rsp_valid = 1'b1; rsp_ra = {up_q, mem_rdata}; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      up_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && take && op == OP_CALL) up_q <= cmd_ra[RA_W-1:8];
      if (state_q == ST_RET_MID) up_q[UP_W-1:8] <= mem_rdata[HI_W-1:0];
      if (state_q == ST_RET_LO)  up_q[7:0]      <= mem_rdata;
    end
  end
endmodule

// File: rtl/stack_fault.sv
module stack_fault
  import stack_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FLOOR  = 16'h0100,
  parameter bit                ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              fault
);
  logic hit;
  assign hit = ENABLE && mem_we && (mem_addr <= FLOOR);

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= fault | hit;
  end
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stack_pkg::*;
#(
  parameter int                RA_W      = 22,
  parameter logic [ADDR_W-1:0] SRAM_LAST = 16'h04FF,
  parameter logic [ADDR_W-1:0] FLOOR     = 16'h0100,
  parameter bit                HAS_HIGH  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic [RA_W-1:0]   cmd_ra,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [RA_W-1:0]   rsp_ra,
  output logic              busy,
  output logic              fault,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic [ADDR_W-1:0] sp_cur;
  logic              step_dn, step_up;

  stack_ptr #(.RESET_VAL(SRAM_LAST), .HAS_HIGH(HAS_HIGH)) u_ptr (
    .clk, .rst_n, .step_dn, .step_up, .reg_we, .reg_sel, .reg_wdata,
    .sp(sp_cur), .reg_rdata
  );

  stack_seq #(.RA_W(RA_W)) u_seq (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_data, .cmd_ra, .reg_we,
    .sp(sp_cur), .mem_rdata, .cmd_ready, .busy, .mem_addr, .mem_wdata,
    .mem_we, .mem_re, .step_dn, .step_up, .rsp_valid, .rsp_data, .rsp_ra
  );

  stack_fault #(.FLOOR(FLOOR), .ENABLE(HAS_HIGH)) u_fault (
    .clk, .rst_n, .mem_we, .mem_addr, .fault
  );
endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
  parameter logic [15:0] FLOOR    = 16'h0100,
  parameter bit          HAS_HIGH = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic        reg_we,
  input logic        busy,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [15:0] sp_cur,
  input logic        fault,
  input logic        rsp_valid
);
  localparam logic [15:0] MASK = HAS_HIGH ? 16'hFFFF : 16'h00FF;

  logic acc_push, acc_pop, acc_call, acc_ret;
  assign acc_push = cmd_valid && cmd_ready && cmd_op == 2'd0;
  assign acc_pop  = cmd_valid && cmd_ready && cmd_op == 2'd1;
  assign acc_call = cmd_valid && cmd_ready && cmd_op == 2'd2;
  assign acc_ret  = cmd_valid && cmd_ready && cmd_op == 2'd3;

  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push |-> mem_we && mem_addr == sp_cur);
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push |=> sp_cur == (($past(sp_cur) - 16'd1) & MASK));
  p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop |=> sp_cur == (($past(sp_cur) + 16'd1) & MASK));
  p_pop_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop |=> rsp_valid);
  p_call_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_call |=> ##2 (sp_cur == (($past(sp_cur, 3) - 16'd3) & MASK)));
  p_ret_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ret |=> ##2 rsp_valid);
  p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  p_reg_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !busy |-> !cmd_ready && !mem_we && !mem_re);
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  generate
    if (HAS_HIGH) begin : g_floor
      p_floor_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_addr <= FLOOR |=> fault);
    end else begin : g_narrow
      p_high_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sp_cur[15:8] == 8'h00 && !fault);
    end
  endgenerate
endmodule

bind stack_engine stack_engine_chk #(.FLOOR(FLOOR), .HAS_HIGH(HAS_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .reg_we(reg_we), .busy(busy), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .sp_cur(sp_cur), .fault(fault),
  .rsp_valid(rsp_valid)
);

// File: tb/sim_stack_engine.sv
`timescale 1ns/1ps
module sim_stack_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_data = '0;
  logic [21:0] cmd_ra = '0;
  logic        rsp_valid, busy, fault, mem_we, mem_re;
  logic [7:0]  rsp_data, mem_wdata, mem_rdata, reg_rdata;
  logic [21:0] rsp_ra;
  logic [15:0] mem_addr;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;

  stack_engine u0 (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_data, .cmd_ra,
    .rsp_valid, .rsp_data, .rsp_ra, .busy, .fault, .mem_addr, .mem_wdata,
    .mem_we, .mem_re, .mem_rdata, .reg_we, .reg_sel, .reg_wdata, .reg_rdata
  );

  // narrow variant, register port only
  logic        n_ready, n_rsp_valid, n_busy, n_fault, n_we, n_re;
  logic [7:0]  n_rsp_data, n_wdata, n_rdata;
  logic [21:0] n_rsp_ra;
  logic [15:0] n_addr;
  logic        n_reg_we = 1'b0, n_reg_sel = 1'b0;
  logic [7:0]  n_reg_wdata = '0;

  stack_engine #(.SRAM_LAST(16'h00DF), .HAS_HIGH(1'b0)) u1 (
    .clk, .rst_n, .cmd_valid(1'b0), .cmd_ready(n_ready), .cmd_op(2'd0),
    .cmd_data(8'h00), .cmd_ra(22'h0), .rsp_valid(n_rsp_valid),
    .rsp_data(n_rsp_data), .rsp_ra(n_rsp_ra), .busy(n_busy), .fault(n_fault),
    .mem_addr(n_addr), .mem_wdata(n_wdata), .mem_we(n_we), .mem_re(n_re),
    .mem_rdata(8'h00), .reg_we(n_reg_we), .reg_sel(n_reg_sel),
    .reg_wdata(n_reg_wdata), .reg_rdata(n_rdata)
  );

  // SRAM model: one-cycle read latency
  logic [7:0] bmem [1024];
  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[9:0]];
  end

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { bit is_ra; logic [7:0] d; logic [21:0] ra; } exp_t;
  exp_t sb[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) chk("R3/R5 unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_ra) chk("R5 return address", {10'd0, rsp_ra}, {10'd0, e.ra});
        else         chk("R3 popped byte", {24'd0, rsp_data}, {24'd0, e.d});
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic [21:0] ra);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_ra = ra;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic exp_byte(input logic [7:0] d);
    exp_t e; e.is_ra = 0; e.d = d; e.ra = '0; sb.push_back(e);
  endtask

  task automatic exp_ra(input logic [21:0] ra);
    exp_t e; e.is_ra = 1; e.d = '0; e.ra = ra; sb.push_back(e);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic get_sp(output logic [15:0] v);
    reg_sel = 1'b1; #1 v[15:8] = reg_rdata;
    reg_sel = 1'b0; #1 v[7:0]  = reg_rdata;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  logic [15:0] sp;
  logic [7:0]  nb;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    get_sp(sp);
    chk("R1 reset pointer", {16'd0, sp}, 32'h04FF);
    chk("R1 reset fault", {31'd0, fault}, 32'd0);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset ready", {31'd0, cmd_ready}, 32'd1);

    // R2: pushes
    issue(2'd0, 8'hA5, '0);
    get_sp(sp);
    chk("R2 pointer after push", {16'd0, sp}, 32'h04FE);
    chk("R2 byte at old pointer", {24'd0, bmem[10'h0FF]}, 32'hA5);
    issue(2'd0, 8'h3C, '0);
    issue(2'd0, 8'h77, '0);
    get_sp(sp);
    chk("R2 pointer after three pushes", {16'd0, sp}, 32'h04FC);

    // R3: pops in LIFO order
    exp_byte(8'h77);
    issue(2'd1, '0, '0);
    chk("R3 response one cycle after accept", {31'd0, rsp_valid}, 32'd1);
    exp_byte(8'h3C);
    issue(2'd1, '0, '0);
    wait_idle();
    get_sp(sp);
    chk("R3 pointer after two pops", {16'd0, sp}, 32'h04FE);

    // R4: call stores low, mid, high at descending addresses
    issue(2'd2, '0, 22'h2A5C3E);
    chk("R6 busy during call", {31'd0, busy}, 32'd1);
    chk("R6 not ready during call", {31'd0, cmd_ready}, 32'd0);
    wait_idle();
    get_sp(sp);
    chk("R4 pointer after call", {16'd0, sp}, 32'h04FB);
    chk("R4 low byte first", {24'd0, bmem[10'h0FE]}, 32'h3E);
    chk("R4 middle byte", {24'd0, bmem[10'h0FD]}, 32'h5C);
    chk("R4 high byte last", {24'd0, bmem[10'h0FC]}, 32'h2A);

    // R5: nested call/return
    issue(2'd2, '0, 22'h13579B);
    wait_idle();
    exp_ra(22'h13579B);
    issue(2'd3, '0, '0);
    wait_idle();
    exp_ra(22'h2A5C3E);
    issue(2'd3, '0, '0);
    wait_idle();
    @(negedge clk);
    get_sp(sp);
    chk("R5 pointer after returns", {16'd0, sp}, 32'h04FE);
    exp_byte(8'hA5);
    issue(2'd1, '0, '0);
    wait_idle();

    // R6: push offered while busy is dropped
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_ra = 22'h3FFF01;
    @(negedge clk);
    cmd_op = 2'd0; cmd_data = 8'hEE;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    get_sp(sp);
    chk("R6 push during busy ignored", {16'd0, sp}, 32'h04FC);
    exp_ra(22'h3FFF01);
    issue(2'd3, '0, '0);
    wait_idle();

    // R7: register writes take effect on next clock
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h80;
    #1 chk("R7 low not yet written", {24'd0, reg_rdata}, 32'hFF);
    @(negedge clk);
    reg_we = 1'b0;
    get_sp(sp);
    chk("R7 low byte written", {16'd0, sp}, 32'h0480);
    wr_reg(1'b1, 8'h03);
    get_sp(sp);
    chk("R7 high byte written", {16'd0, sp}, 32'h0380);

    // R8: register write beats a push in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h40;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 8'h99;
    #1 chk("R8 ready low on register write", {31'd0, cmd_ready}, 32'd0);
    chk("R8 no SRAM write", {31'd0, mem_we}, 32'd0);
    @(negedge clk);
    reg_we = 1'b0; cmd_valid = 1'b0;
    get_sp(sp);
    chk("R8 pointer from register only", {16'd0, sp}, 32'h0340);

    // R9: fault on write at or below 0x0100
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b0, 8'h02);
    issue(2'd0, 8'h11, '0);
    issue(2'd0, 8'h22, '0);
    chk("R9 no fault above floor", {31'd0, fault}, 32'd0);
    issue(2'd0, 8'h33, '0);
    chk("R9 fault at floor", {31'd0, fault}, 32'd1);
    wr_reg(1'b1, 8'h03);
    issue(2'd0, 8'h44, '0);
    chk("R9 fault stays set", {31'd0, fault}, 32'd1);

    // R10: narrow variant
    n_reg_sel = 1'b0; #1 nb = n_rdata;
    chk("R10 narrow reset low byte", {24'd0, nb}, 32'hDF);
    n_reg_sel = 1'b1; #1 nb = n_rdata;
    chk("R10 narrow high reads zero", {24'd0, nb}, 32'h00);
    @(negedge clk);
    n_reg_we = 1'b1; n_reg_sel = 1'b1; n_reg_wdata = 8'h55;
    @(negedge clk);
    n_reg_we = 1'b0;
    #1 nb = n_rdata;
    chk("R10 narrow high write ignored", {24'd0, nb}, 32'h00);
    n_reg_sel = 1'b0; #1 nb = n_rdata;
    chk("R10 narrow low unchanged by high write", {24'd0, nb}, 32'hDF);

    repeat (2) @(negedge clk);
    chk("R5 all responses seen", sb.size(), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule